// File: doc/BRIEF.md
# Grayscale Framebuffer Bus Adapter

This block is a memory-mapped slave that sits between a processor bus and a small display buffer of 32-bit pixels. The processor sees a 1 MiB aperture. Inside it, a logical screen of `SCREEN_W` by `SCREEN_H` byte positions is laid out with a row stride of `SCREEN_W` bytes. Only a `VIS_W` by `VIS_H` window in the lower right corner of that screen is backed by storage. The deployed configuration uses a 1024x768 logical screen with a 640x264 window. The defaults are kept smaller so the buffer stays modest.

Each bus byte stands for one gray pixel. A byte write copies the value into the three colour bytes of the pixel. A byte read returns the low colour byte. Halfword and word accesses are broken into single-byte accesses at rising addresses, one per clock. The most significant byte goes to the lowest address. Read bytes are collected into a shift register and returned on a separate response strobe.

A display refresher reads pixels through its own synchronous port. It also watches a sticky dirty flag, which it clears with a pulse.

Top module: `gray_fb_adapter`

## Requirements
- R1: The byte at bus address `BASE_ADDR + (SCREEN_H-VIS_H)*SCREEN_W + (SCREEN_W-VIS_W) + y*SCREEN_W + x`, with x < VIS_W and y < VIS_H, is pixel (x, y), stored at buffer word `y*VIS_W + x`.
- R2: A byte write to a visible pixel stores the written value into bits [7:0], [15:8] and [23:16] of that pixel word, and leaves bits [31:24] unchanged.
- R3: A byte read (`req_size` = 0) of a visible pixel returns bits [7:0] of that pixel word in `rsp_rdata[7:0]`, with `rsp_rdata[31:8]` zero.
- R4: A byte address that does not reach a visible pixel is out of range: reads of it yield zero and writes to it change no pixel and do not set `dirty`. This covers x >= VIS_W, y >= VIS_H, addresses below the window origin and addresses outside the 1 MiB aperture.
- R5: A halfword write (`req_size` = 1) stores `req_wdata[15:8]` at the request address and `req_wdata[7:0]` at the next address. A word write (`req_size` = 2 or 3) stores `req_wdata[31:24]`, `[23:16]`, `[15:8]` and `[7:0]` at four rising addresses. Each of these bytes follows R2 and R4 on its own.
- R6: A halfword read returns {16'h0, byte(a), byte(a+1)}. A word read returns {byte(a), byte(a+1), byte(a+2), byte(a+3)}. Each byte follows R3 and R4 on its own.
- R7: `req_ready` is high while idle. After a request is accepted, it is low for exactly 1, 2 or 4 cycles for sizes 0, 1 and 2/3, then high again.
- R8: For a read, `rsp_valid` is a one-cycle pulse in the first cycle after the request completes, with `rsp_rdata` valid in that cycle. Writes produce no response.
- R9: `dirty` is set by every byte stored in a visible pixel. It stays set until a cycle with `dirty_clr` high and no byte being stored. A byte stored in the same cycle as the clear leaves it set.
- R10: `disp_pixel` shows the buffer word at `disp_index` one clock after `disp_index` is presented.
- R11: After reset, `req_ready` = 1, `rsp_valid` = 0 and `dirty` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Adapter idle; request accepted when both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | 32 | Byte address of the first byte |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Read data strobe |
| rsp_rdata | output | 32 | Assembled read data, right-aligned |
| dirty | output | 1 | Buffer changed since the last clear |
| dirty_clr | input | 1 | Clear pulse from the refresher |
| disp_index | input | IDX_W (9) | Refresher pixel index |
| disp_pixel | output | 32 | Pixel word, one cycle after index |

## Verification
The hardest situation to reach is the collision of a clear pulse with a byte being stored. The bench drives the clear during the single busy cycle of a byte write, so it meets the store on the same edge. The other difficult cases are wide accesses whose bytes fall partly outside the window. The bench places halfword and word accesses at the right edge of a row, so that later bytes land at x = VIS_W. Each byte must then be dropped or read as zero on its own. A per-pixel model in the bench, checked against full sweeps of the refresher port, shows that no stray byte reached the buffer.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } seq_state_e;

    typedef struct packed {
        seq_state_e  state;
        logic [31:0] addr;      // address of the byte being sequenced
        logic [2:0]  left;      // bytes still to process
        logic        wr;
        logic [31:0] wsh;       // write bytes, next one in [31:24]
        logic [23:0] rsh;       // read bytes gathered so far
        logic        rsp_valid;
        logic [31:0] rsp_data;
        logic        dirty;
    } seq_regs_t;

    function automatic logic [2:0] byte_count(input logic [1:0] size);
        case (size)
            2'd0:    byte_count = 3'd1;
            2'd1:    byte_count = 3'd2;
            default: byte_count = 3'd4;
        endcase
    endfunction

    // Move the first byte to be stored into the top lane.
    function automatic logic [31:0] align_wdata(input logic [1:0] size, input logic [31:0] data);
        case (size)
            2'd0:    align_wdata = {data[7:0], 24'h0};
            2'd1:    align_wdata = {data[15:0], 16'h0};
            default: align_wdata = data;
        endcase
    endfunction

endpackage

// File: rtl/fbg_addr_map.sv
module fbg_addr_map #(
    parameter logic [31:0] BASE_ADDR      = 32'h5080_0000,
    parameter int unsigned APERTURE_BYTES = 1048576,
    parameter int unsigned SCREEN_W       = 1024,
    parameter int unsigned SCREEN_H       = 768,
    parameter int unsigned VIS_W          = 32,
    parameter int unsigned VIS_H          = 16,
    parameter int unsigned IDX_W          = 9
) (
    input  logic [31:0]      addr,
    output logic             hit,
    output logic [IDX_W-1:0] index
);
    localparam int unsigned XW      = $clog2(SCREEN_W);
    localparam int unsigned WIN_OFF = (SCREEN_H - VIS_H) * SCREEN_W + (SCREEN_W - VIS_W);

    logic [31:0]    rel;
    logic [31:0]    off;
    logic [XW-1:0]  xpos;
    logic [31-XW:0] ypos;

    always_comb begin
        rel   = addr - BASE_ADDR;
        off   = rel - 32'(WIN_OFF);
        xpos  = off[XW-1:0];
        ypos  = off[31:XW];
        hit   = (rel < 32'(APERTURE_BYTES)) && (32'(xpos) < 32'(VIS_W)) && (32'(ypos) < 32'(VIS_H));
        index = IDX_W'(ypos) * IDX_W'(VIS_W) + IDX_W'(xpos);
    end
endmodule

// File: rtl/fbg_pixel_ram.sv
module fbg_pixel_ram #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned IDX_W = 9
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] bus_index,
    input  logic             bus_we,
    input  logic [7:0]       bus_wbyte,
    output logic [7:0]       bus_rbyte,
    input  logic [IDX_W-1:0] disp_index,
    output logic [31:0]      disp_pixel
);
    logic [31:0] mem [DEPTH];

    // Bus port: gray fill of the three colour lanes, top lane kept.
    always_ff @(posedge clk) begin
        if (bus_we) begin
            mem[bus_index][23:0] <= {3{bus_wbyte}};
        end
    end

    assign bus_rbyte = mem[bus_index][7:0];

    // Refresher port: registered read.
    always_ff @(posedge clk) begin
        disp_pixel <= mem[disp_index];
    end
endmodule

// File: rtl/gray_fb_adapter.sv
module gray_fb_adapter
    import fbg_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR      = 32'h5080_0000,
    parameter int unsigned APERTURE_BYTES = 1048576,
    parameter int unsigned SCREEN_W       = 1024,
    parameter int unsigned SCREEN_H       = 768,
    parameter int unsigned VIS_W          = 32,
    parameter int unsigned VIS_H          = 16,
    localparam int unsigned DEPTH         = VIS_W * VIS_H,
    localparam int unsigned IDX_W         = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [1:0]       req_size,
    input  logic [31:0]      req_addr,
    input  logic [31:0]      req_wdata,
    output logic             rsp_valid,
    output logic [31:0]      rsp_rdata,
    output logic             dirty,
    input  logic             dirty_clr,
    input  logic [IDX_W-1:0] disp_index,
    output logic [31:0]      disp_pixel
);
    seq_regs_t        q, d;
    logic             bus_hit;
    logic [IDX_W-1:0] bus_index;
    logic             ram_we;
    logic [7:0]       ram_byte;
    logic [7:0]       rd_byte;

    fbg_addr_map #(
        .BASE_ADDR      (BASE_ADDR),
        .APERTURE_BYTES (APERTURE_BYTES),
        .SCREEN_W       (SCREEN_W),
        .SCREEN_H       (SCREEN_H),
        .VIS_W          (VIS_W),
        .VIS_H          (VIS_H),
        .IDX_W          (IDX_W)
    ) i_map (
        .addr  (q.addr),
        .hit   (bus_hit),
        .index (bus_index)
    );

    fbg_pixel_ram #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) i_ram (
        .clk        (clk),
        .bus_index  (bus_index),
        .bus_we     (ram_we),
        .bus_wbyte  (q.wsh[31:24]),
        .bus_rbyte  (ram_byte),
        .disp_index (disp_index),
        .disp_pixel (disp_pixel)
    );

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        ram_we      = 1'b0;
        rd_byte     = 8'h00;
        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.state = ST_BUSY;
                    d.addr  = req_addr;
                    d.left  = byte_count(req_size);
                    d.wr    = req_write;
                    d.wsh   = align_wdata(req_size, req_wdata);
                    d.rsh   = '0;
                end
            end
            ST_BUSY: begin
                if (q.wr) begin
                    ram_we = bus_hit;
                end else begin
                    rd_byte = bus_hit ? ram_byte : 8'h00;
                end
                d.rsh  = {q.rsh[15:0], rd_byte};
                d.wsh  = {q.wsh[23:0], 8'h00};
                d.addr = q.addr + 32'd1;
                d.left = q.left - 3'd1;
                if (q.left == 3'd1) begin
                    d.state     = ST_IDLE;
                    d.rsp_valid = !q.wr;
                    d.rsp_data  = {q.rsh, rd_byte};
                end
            end
        endcase
        if (dirty_clr) d.dirty = 1'b0;
        if (ram_we)    d.dirty = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready = (q.state == ST_IDLE);
    assign rsp_valid = q.rsp_valid;
    assign rsp_rdata = q.rsp_data;
    assign dirty     = q.dirty;
endmodule

// File: rtl/gray_fb_adapter_chk.sv
module gray_fb_adapter_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic req_write,
    input logic rsp_valid,
    input logic dirty,
    input logic dirty_clr,
    input logic ram_we
);
    logic [3:0] busy_cnt;
    logic       last_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            last_wr  <= 1'b0;
        end else begin
            busy_cnt <= req_ready ? 4'd0 : busy_cnt + 4'd1;
            if (req_valid && req_ready) last_wr <= req_write;
        end
    end

    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n) req_valid && req_ready |=> !req_ready); // R7
    AST_BUSY_BOUNDED:     assert property (@(posedge clk) disable iff (!rst_n) !req_ready |-> busy_cnt < 4'd4); // R7
    AST_RSP_SINGLE:       assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R8
    AST_RSP_READ_ONLY:    assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> !last_wr && req_ready); // R8
    AST_DIRTY_SET:        assert property (@(posedge clk) disable iff (!rst_n) ram_we |=> dirty); // R9
    AST_DIRTY_HOLD:       assert property (@(posedge clk) disable iff (!rst_n) dirty && !dirty_clr |=> dirty); // R9
    AST_DIRTY_CLEAR:      assert property (@(posedge clk) disable iff (!rst_n) dirty_clr && !ram_we |=> !dirty); // R9
    AST_STORE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) ram_we |-> last_wr && !req_ready); // R4
endmodule

bind gray_fb_adapter gray_fb_adapter_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .dirty     (dirty),
    .dirty_clr (dirty_clr),
    .ram_we    (ram_we)
);

// File: tb/test_gray_fb_adapter.sv
module test_gray_fb_adapter;
    localparam logic [31:0] BASE = 32'h5080_0000;
    localparam int SW = 1024;
    localparam int SH = 768;
    localparam int VW = 32;
    localparam int VH = 16;
    localparam int NPIX = VW * VH;
    localparam int IW = $clog2(NPIX);
    localparam logic [31:0] ORIGIN = BASE + 32'((SH - VH) * SW + (SW - VW));

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [31:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          dirty;
    logic          dirty_clr = 1'b0;
    logic [IW-1:0] disp_index = '0;
    logic [31:0]   disp_pixel;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [NPIX];

    always #10 clk = ~clk;

    gray_fb_adapter i_gray_fb_adapter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dirty(dirty), .dirty_clr(dirty_clr), .disp_index(disp_index),
        .disp_pixel(disp_pixel)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pa(input int x, input int y);
        return ORIGIN + 32'(y * SW + x);
    endfunction

    function automatic logic [7:0] pat(input int x, input int y);
        return 8'((x * 7 + y * 13 + 1) & 255);
    endfunction

    // Returns the busy cycle count, the response flag and the read data.
    task automatic bus(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] wd, output logic [31:0] rd, output int busy,
                       output logic got);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0;
        while (!req_ready) begin
            busy++;
            @(negedge clk);
        end
        got = rsp_valid;
        rd = rsp_rdata;
    endtask

    // Model update for one byte address.
    task automatic model_byte(input logic [31:0] a, input logic [7:0] v);
        logic [31:0] off;
        int x, y;
        off = a - ORIGIN;
        x = int'(off % SW);
        y = int'(off / SW);
        if (a >= ORIGIN && x < VW && y < VH) model[y * VW + x] = v;
    endtask

    function automatic logic [7:0] model_rd(input logic [31:0] a);
        logic [31:0] off;
        int x, y;
        off = a - ORIGIN;
        x = int'(off % SW);
        y = int'(off / SW);
        if (a >= ORIGIN && x < VW && y < VH) return model[y * VW + x];
        return 8'h00;
    endfunction

    task automatic disp_rd(input int idx, output logic [31:0] px);
        @(negedge clk);
        disp_index = IW'(idx);
        @(negedge clk);
        px = disp_pixel;
    endtask

    task automatic sweep_disp(input string tag);
        logic [31:0] px;
        for (int i = 0; i < NPIX; i++) begin
            disp_rd(i, px);
            chk(px[23:0] == {3{model[i]}}, tag, px, {8'h0, {3{model[i]}}});
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        dirty_clr = 1'b1;
        @(negedge clk);
        dirty_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd, px, b3_before;
        int busy;
        logic got;
        logic [31:0] oor [4];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(req_ready == 1'b1, "R11 ready", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R11 rsp_valid", 32'(rsp_valid), 32'd0);
        chk(dirty == 1'b0, "R11 dirty", 32'(dirty), 32'd0);

        disp_rd(5, px);
        b3_before = px;

        // R1 R2 R7 R8: byte write sweep over every visible pixel
        for (int y = 0; y < VH; y++) begin
            for (int x = 0; x < VW; x++) begin
                bus(1'b1, 2'd0, pa(x, y), {24'hABCDEF, pat(x, y)}, rd, busy, got);
                model_byte(pa(x, y), pat(x, y));
                if (x == 0) begin
                    chk(busy == 1, "R7 byte busy", 32'(busy), 32'd1);
                    chk(got == 1'b0, "R8 no write rsp", 32'(got), 32'd0);
                end
            end
        end
        sweep_disp("R1 R2 gray fill");
        disp_rd(5, px);
        chk(px[31:24] == b3_before[31:24], "R2 top lane kept", px, b3_before);
        chk(dirty == 1'b1, "R9 dirty after writes", 32'(dirty), 32'd1);

        // R3: byte read sweep
        for (int y = 0; y < VH; y++) begin
            for (int x = 0; x < VW; x++) begin
                bus(1'b0, 2'd0, pa(x, y), 32'h0, rd, busy, got);
                chk(got && rd == {24'h0, pat(x, y)}, "R3 byte read", rd, {24'h0, pat(x, y)});
            end
        end

        // R4: out-of-range accesses
        pulse_clr();
        chk(dirty == 1'b0, "R9 cleared", 32'(dirty), 32'd0);
        oor[0] = pa(VW, 0);
        oor[1] = pa(0, VH);
        oor[2] = ORIGIN - 32'd1;
        oor[3] = pa(3, 2) + 32'h0010_0000;
        for (int k = 0; k < 4; k++) begin
            bus(1'b1, 2'd0, oor[k], 32'h0000_005A, rd, busy, got);
            bus(1'b0, 2'd0, oor[k], 32'h0, rd, busy, got);
            chk(rd == 32'h0, "R4 oor read", rd, 32'h0);
        end
        chk(dirty == 1'b0, "R4 oor no dirty", 32'(dirty), 32'd0);
        sweep_disp("R4 oor no store");

        // R5 R6 R7: halfword and word
        bus(1'b1, 2'd1, pa(2, 1), 32'hFFFF_A1B2, rd, busy, got);
        model_byte(pa(2, 1), 8'hA1); model_byte(pa(3, 1), 8'hB2);
        chk(busy == 2, "R7 half busy", 32'(busy), 32'd2);
        bus(1'b1, 2'd2, pa(4, 2), 32'h1122_3344, rd, busy, got);
        model_byte(pa(4, 2), 8'h11); model_byte(pa(5, 2), 8'h22);
        model_byte(pa(6, 2), 8'h33); model_byte(pa(7, 2), 8'h44);
        chk(busy == 4, "R7 word busy", 32'(busy), 32'd4);
        bus(1'b0, 2'd2, pa(4, 2), 32'h0, rd, busy, got);
        chk(got && rd == 32'h1122_3344, "R6 word read", rd, 32'h1122_3344);
        bus(1'b0, 2'd1, pa(2, 1), 32'h0, rd, busy, got);
        chk(got && rd == 32'h0000_A1B2, "R6 half read", rd, 32'h0000_A1B2);
        bus(1'b0, 2'd3, pa(4, 2), 32'h0, rd, busy, got);
        chk(busy == 4 && rd == 32'h1122_3344, "R7 size3 as word", rd, 32'h1122_3344);

        // R4 R5 R6: accesses straddling the right edge
        bus(1'b1, 2'd1, pa(VW - 1, 3), 32'h0000_5566, rd, busy, got);
        model_byte(pa(VW - 1, 3), 8'h55); model_byte(pa(VW, 3), 8'h66);
        bus(1'b0, 2'd1, pa(VW - 1, 3), 32'h0, rd, busy, got);
        chk(rd == 32'h0000_5500, "R4 R6 half straddle", rd, 32'h0000_5500);
        bus(1'b1, 2'd2, pa(VW - 3, 4), 32'hC1C2_C3C4, rd, busy, got);
        for (int k = 0; k < 4; k++) model_byte(pa(VW - 3 + k, 4), 8'(32'hC1C2_C3C4 >> (24 - 8 * k)));
        bus(1'b0, 2'd2, pa(VW - 2, 3), 32'h0, rd, busy, got);
        chk(rd == {model_rd(pa(VW - 2, 3)), 8'h55, 16'h0}, "R4 R6 word straddle", rd,
            {model_rd(pa(VW - 2, 3)), 8'h55, 16'h0});

        // R9: clear colliding with a store, then holding
        pulse_clr();
        chk(dirty == 1'b0, "R9 clear again", 32'(dirty), 32'd0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'd0; req_addr = pa(9, 9); req_wdata = 32'h77;
        @(negedge clk);
        req_valid = 1'b0;
        dirty_clr = 1'b1;
        @(negedge clk);
        dirty_clr = 1'b0;
        model_byte(pa(9, 9), 8'h77);
        chk(dirty == 1'b1, "R9 set wins", 32'(dirty), 32'd1);
        repeat (5) @(negedge clk);
        chk(dirty == 1'b1, "R9 sticky", 32'(dirty), 32'd1);

        // R10: registered refresher port latency
        @(negedge clk);
        disp_index = IW'(9 * VW + 9);
        @(posedge clk);
        #1 disp_index = IW'(0);
        @(negedge clk);
        chk(disp_pixel[7:0] == 8'h77, "R10 one cycle", disp_pixel, 32'h77);

        sweep_disp("R1 R5 final image");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule